// File: doc/BRIEF.md
# Serial Transmitter with Counted Break Sequence

This block is an asynchronous-format serial transmitter. It takes characters over a valid/ready byte interface and shifts each one out on the line, one bit per bit-rate tick. A character is a zero start bit, then 5 to DATA_W data bits sent least significant bit first, then an optional parity bit, then one or two stop bits of value one. A separate clock-enable pulse, `tick_i`, sets the bit rate, so the block has no divider of its own.

A stop-transmit command ends normal output. If a character is on the line when the command arrives, that character is sent to its last stop bit. Straight after it, the block sends a programmed number of break characters. A break character is a run of zero bits exactly one character period long, and that period is worked out from the current character format. When the last break bit has gone, the line returns high and `done_o` is high for one clock. A break count of zero sends no break and reports done at once.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset and whenever no character or break is in progress, `txd_o` is 1, `done_o` is 0 and `ready_o` is 1 unless `stop_cmd_i` is high in that cycle.
- R2: A character accepted when `valid_i` and `ready_o` are both high at a clock edge is sent as a bit sequence. The sequence is one 0 start bit, then `dlen_i` data bits sent least significant bit first, then a parity bit if `par_en_i` is 1, then 1 stop bit of value 1, or 2 stop bits if `stop2_i` is 1. The parity bit is the XOR of the data bits when `par_odd_i` is 0, and its inverse when `par_odd_i` is 1. Each bit lasts until a tick, so a character lasts L = 2 + `dlen_i` + `par_en_i` + `stop2_i` ticks.
- R3: If `stop_cmd_i` is pulsed while a character is being sent, that character completes in full. The break begins on the tick that ends its last stop bit, with no idle gap before it.
- R4: A break is `brk_cnt_i` × L consecutive zero bits, counted in ticks. `brk_cnt_i` is sampled when the break starts.
- R5: `stop_cmd_i` in an idle cycle with a non-zero count starts the break at that clock edge, and `txd_o` is 0 from the next cycle onward.
- R6: In the cycle after the edge that ends the last break bit, `txd_o` is 1 and `done_o` is 1. In the cycle after that, `done_o` is 0 again.
- R7: With `brk_cnt_i` = 0, no zero bit is sent. `done_o` pulses in the cycle after the command when the block is idle, or in the cycle after the character ends when a character is in progress.
- R8: While a character or a break is in progress, `ready_o` is 0. A `stop_cmd_i` pulse during a break has no effect: no extra break bit is sent and no further `done_o` pulse occurs.
- R9: While a character or a break is in progress, `txd_o` changes only at a clock edge at which `tick_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-rate enable, one pulse per bit time |
| data_i | input | DATA_W | Character to send |
| valid_i | input | 1 | `data_i` holds a character |
| ready_o | output | 1 | Character accepted at this edge if `valid_i` is high |
| stop_cmd_i | input | 1 | Stop-transmit command pulse |
| brk_cnt_i | input | CNT_W | Number of break characters to send |
| dlen_i | input | LEN_W | Data bits per character, 5 to DATA_W |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even parity when 0 |
| stop2_i | input | 1 | Two stop bits when 1 |
| txd_o | output | 1 | Serial line, idles high |
| done_o | output | 1 | One-clock pulse when the stop sequence ends |

## Verification
Timing of each result:
- After an accepted character, the start bit is on the line from the next cycle.
- Bit k of the character is on the line in the cycle where the k-th tick after acceptance is high.
- Break bits follow the character with no gap. The break ends after exactly count × L ticks.
- `done_o` is high in the cycle straight after the edge of the final tick. For a zero count in idle, it is high in the cycle straight after the command edge.

How the bench checks this:
- The bench samples `txd_o` at the falling edge of every cycle in which the tick is high. This gives exactly one sample per bit.
- It compares those samples with frames it builds arithmetically, sweeping every character format.
- It checks `done_o` and the idle line at the very next falling edge, which pins the end of the sequence to the exact cycle.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_BRK} tx_state_e;

  function automatic int unsigned char_bits(int unsigned dlen, logic par, logic stop2);
    return 32'd2 + dlen + (par ? 32'd1 : 32'd0) + (stop2 ? 32'd1 : 32'd0);
  endfunction
endpackage

// File: rtl/uart_brk_frame.sv
module uart_brk_frame #(
  parameter int DATA_W = 9,
  parameter int FRM_W  = DATA_W + 4,
  parameter int LEN_W  = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  dlen_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  output logic [FRM_W-1:0]  frame_o,
  output logic [LEN_W-1:0]  len_o
);
  logic par;

  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    par        = par_odd_i;
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) < dlen_i) begin
        frame_o[i+1] = data_i[i];
        par          = par ^ data_i[i];
      end
    end
    // parity sits right after the last data bit
    for (int i = 0; i <= DATA_W; i++) begin
      if (par_en_i && LEN_W'(i) == dlen_i) frame_o[i+1] = par;
    end
    len_o = LEN_W'(uart_brk_pkg::char_bits(32'(dlen_i), par_en_i, stop2_i));
  end
endmodule

// File: rtl/uart_brk_bitcnt.sv
module uart_brk_bitcnt #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             wrap_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             last;

  assign last   = (cnt_q == len_i - 1'b1);
  assign wrap_o = run_i & tick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_brk_chcnt.sv
module uart_brk_chcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] left_q;

  assign last_o = (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (load_i) left_q <= val_i;
    else if (dec_i)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter  int DATA_W = 9,
  parameter  int CNT_W  = 16,
  localparam int FRM_W  = DATA_W + 4,
  localparam int LEN_W  = $clog2(FRM_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              stop_cmd_i,
  input  logic [CNT_W-1:0]  brk_cnt_i,
  input  logic [LEN_W-1:0]  dlen_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  output logic              txd_o,
  output logic              done_o
);
  import uart_brk_pkg::*;

  tx_state_e        state_q;
  logic [FRM_W-1:0] shreg_q, frame;
  logic [LEN_W-1:0] len_q, fmt_len;
  logic             pend_q, done_q;
  logic             idle, busy, in_brk, wrap, ch_last, cnt_nz, stop_now, brk_start;

  assign idle     = (state_q == ST_IDLE);
  assign busy     = ~idle;
  assign in_brk   = (state_q == ST_BRK);
  assign cnt_nz   = |brk_cnt_i;
  assign stop_now = pend_q | stop_cmd_i;
  assign brk_start = cnt_nz & ((idle & stop_cmd_i) | ((state_q == ST_DATA) & wrap & stop_now));

  assign ready_o = idle & ~stop_cmd_i;
  assign done_o  = done_q;
  assign txd_o   = (state_q == ST_DATA) ? shreg_q[0] : ~in_brk;

  uart_brk_frame #(.DATA_W(DATA_W), .FRM_W(FRM_W), .LEN_W(LEN_W)) u_frame (
    .data_i(data_i), .dlen_i(dlen_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .stop2_i(stop2_i), .frame_o(frame), .len_o(fmt_len)
  );

  uart_brk_bitcnt #(.LEN_W(LEN_W)) u_bitcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .tick_i(tick_i),
    .len_i(len_q), .wrap_o(wrap)
  );

  uart_brk_chcnt #(.CNT_W(CNT_W)) u_chcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(brk_start), .val_i(brk_cnt_i),
    .dec_i(in_brk & wrap), .last_o(ch_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '1;
      len_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          len_q <= fmt_len;
          if (stop_cmd_i) begin
            if (cnt_nz) state_q <= ST_BRK;
            else        done_q  <= 1'b1;
          end else if (valid_i) begin
            state_q <= ST_DATA;
            shreg_q <= frame;
          end
        end
        ST_DATA: begin
          if (tick_i) shreg_q <= {1'b1, shreg_q[FRM_W-1:1]};
          if (wrap) begin
            pend_q <= 1'b0;
            if (stop_now && cnt_nz) state_q <= ST_BRK;
            else begin
              state_q <= ST_IDLE;
              done_q  <= stop_now;
            end
          end else if (stop_cmd_i) begin
            pend_q <= 1'b1;
          end
        end
        ST_BRK: begin
          // stop commands are ignored here
          if (wrap && ch_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_brk_chk.sv
module uart_brk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic ready_o,
  input logic txd_o,
  input logic done_o,
  input logic busy_i,
  input logic in_brk_i,
  input logic wrap_i
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> txd_o);

  assert_done_line_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (txd_o && !busy_i));

  assert_bit_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !$past(tick_i)) |-> $stable(txd_o));

  assert_brk_after_char_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_brk_i && $past(busy_i) && !$past(in_brk_i)) |-> $past(wrap_i));

  assert_no_ready_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !ready_o);
endmodule

bind uart_brk_tx uart_brk_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ready_o(ready_o),
  .txd_o(txd_o), .done_o(done_o), .busy_i(busy), .in_brk_i(in_brk), .wrap_i(wrap)
);

// File: tb/sim_uart_brk_tx.sv
`timescale 1ns/1ps
module sim_uart_brk_tx;
  localparam int DATA_W = 9;
  localparam int CNT_W  = 16;
  localparam int LEN_W  = 4;

  logic              clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [DATA_W-1:0] data = '0;
  logic              valid = 1'b0, stop = 1'b0;
  logic [CNT_W-1:0]  cnt = '0;
  logic [LEN_W-1:0]  dlen = 4'd8;
  logic              pe = 1'b0, po = 1'b0, s2 = 1'b0;
  logic              ready, txd, done;
  int checks = 0, fails = 0, divc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    divc = (divc + 1) % 4;
    tick = (divc == 0);
  end

  uart_brk_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .data_i(data), .valid_i(valid),
    .ready_o(ready), .stop_cmd_i(stop), .brk_cnt_i(cnt), .dlen_i(dlen),
    .par_en_i(pe), .par_odd_i(po), .stop2_i(s2), .txd_o(txd), .done_o(done)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one sample per tick cycle, plus tallies of ready and done
  task automatic grab(int n, output logic [63:0] v, output int nrdy, output int ndone);
    v = '0; nrdy = 0; ndone = 0;
    for (int i = 0; i < n;) begin
      @(negedge clk);
      nrdy  += int'(ready);
      ndone += int'(done);
      if (tick) begin
        v[i] = txd;
        i++;
      end
    end
  endtask

  function automatic logic [63:0] exp_frame(int d, int len, bit p_en, bit p_odd, bit st2);
    logic [63:0] f = '0;
    int  k = 1;
    bit  p = p_odd;
    for (int i = 0; i < len; i++) begin
      f[k] = d[i];
      p ^= d[i];
      k++;
    end
    if (p_en) begin
      f[k] = p;
      k++;
    end
    f[k] = 1'b1;
    if (st2) f[k+1] = 1'b1;
    return f;
  endfunction

  task automatic send(int d);
    @(posedge clk); #1 valid = 1'b1; data = DATA_W'(d);
    @(negedge clk); chk(ready === 1'b1, "R1", "ready before accept", ready, 1);
    @(posedge clk); #1 valid = 1'b0;
  endtask

  task automatic pulse_stop_after(int cyc);
    repeat (cyc) @(posedge clk);
    #1 stop = 1'b1;
    @(posedge clk); #1 stop = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    if (!finished) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v, e, ones;
    int nr, nd, idx, L, d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(txd === 1'b1, "R1", "reset txd", txd, 1);
    chk(ready === 1'b1, "R1", "reset ready", ready, 1);
    chk(done === 1'b0, "R1", "reset done", done, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    idx = 0;
    for (int ln = 5; ln <= 9; ln++)
      for (int pp = 0; pp < 3; pp++)
        for (int ss = 0; ss < 2; ss++) begin
          @(posedge clk); #1;
          dlen = LEN_W'(ln); pe = (pp != 0); po = (pp == 2); s2 = ss[0];
          L = 2 + ln + int'(pe) + ss;
          idx++;
          d = (idx * 37 + 11) & ((1 << ln) - 1);

          // plain character
          send(d);
          grab(L, v, nr, nd);
          e = exp_frame(d, ln, pe, po, s2);
          chk(v == e, "R2", "frame bits", v, e);
          chk(nr == 0, "R8", "ready low during char", nr, 0);
          chk(nd == 0, "R2", "no done on plain char", nd, 0);
          @(negedge clk);
          chk(txd === 1'b1 && ready === 1'b1, "R1", "idle after char", {txd, ready}, 3);

          // break from idle, stop pulsed again mid-break
          cnt = CNT_W'((idx % 3) + 1);
          pulse_stop_after(1);
          fork
            grab(int'(cnt) * L, v, nr, nd);
            pulse_stop_after(5);
          join
          chk(v == 64'd0, "R5", "idle break all zero", v, 0);
          chk(nr == 0 && nd == 0, "R8", "no ready/done inside break", nr + nd, 0);
          @(negedge clk);
          chk(done === 1'b1 && txd === 1'b1, "R6", "done after idle break", {done, txd}, 3);
          @(negedge clk);
          chk(done === 1'b0, "R6", "done one clock", done, 0);
          grab(2 * L, v, nr, nd);
          ones = (64'd1 << (2 * L)) - 1;
          chk(v == ones && nd == 0, "R8", "stop during break ignored", v, ones);

          // stop during character
          cnt = CNT_W'(idx % 4);
          send(d ^ 3);
          fork
            grab(L + int'(cnt) * L, v, nr, nd);
            pulse_stop_after(6);
          join
          e = exp_frame(d ^ 3, ln, pe, po, s2);
          chk(v == e, "R3", "char then break bits", v, e);
          chk(nd == 0, "R4", "no early done", nd, 0);
          @(negedge clk);
          if (cnt == 0) chk(done === 1'b1 && txd === 1'b1, "R7", "zero count done at char end", {done, txd}, 3);
          else          chk(done === 1'b1 && txd === 1'b1, "R4", "break length count*L", {done, txd}, 3);
          @(negedge clk);
          chk(done === 1'b0, "R6", "done clears", done, 0);

          // zero count from idle
          cnt = '0;
          pulse_stop_after(1);
          @(negedge clk);
          chk(done === 1'b1 && txd === 1'b1, "R7", "zero count idle done", {done, txd}, 3);
          @(negedge clk);
          chk(done === 1'b0 && ready === 1'b1 && txd === 1'b1, "R7", "no break sent", {done, ready, txd}, 3);
        end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule